// File: doc/BRIEF.md
# Locality Ownership Access Gate

This block sits between a bus address decoder and a register file of a security module that exposes five address windows, one per locality (0 to 4). For every decoded access it decides in the same cycle whether the access is performed or aborted. An aborted access must produce no bus acknowledge and must leave the addressed register untouched. The decision depends on the addressed locality, the register identifier, the direction, which locality (if any) currently owns the module, and, for reads of the data FIFO, whether response data is available.

The gate also keeps the ownership state itself. A locality requests or gives up ownership by writing its access-control register. Three hash-sequence registers exist only in locality 4. A write that starts a hash sequence takes ownership for locality 4. A write that ends the sequence gives ownership up again. At most one locality owns the module at a time. The register contents and the hash engine live outside this block.

Top module: `lac_gate`

## Requirements
- R1: After reset no locality owns the module (`owner_valid` = 0, `owner_loc` = 0).
- R2: Any access to a locality number above 4, or with a register identifier above 10, is aborted.
- R3: The access-control register (identifier 0) is performed for reads and writes from every locality 0 to 4, whatever the ownership state.
- R4: A performed access-control write with data bit 0 set and no current owner makes the writing locality the owner from the next cycle. When another locality owns the module, the request has no effect.
- R5: A performed access-control write with data bit 1 set, from the owning locality, clears ownership from the next cycle. This takes priority over bit 0. From a non-owner it has no effect.
- R6: Writes to interrupt enable (1), interrupt vector (2), interrupt status (3), status (5), data FIFO (6) and interface configuration (7) are performed only for the owning locality.
- R7: Reads of identifiers 1, 2, 3, 4 (interrupt capability) and 7 are performed in every ownership state. Reads of status (5) are performed only for the owner.
- R8: A read of the data FIFO (6) is performed only for the owner and only while `fifo_avail` is 1. Otherwise it is aborted.
- R9: Writes to interrupt capability (4) are always aborted.
- R10: A write to hash-start (8) is performed only from locality 4 with no current owner, and then makes locality 4 the owner. Otherwise it is aborted and ownership is unchanged.
- R11: Writes to hash-data (9) and hash-end (10) are performed only from locality 4 while it owns the module. A performed hash-end write clears ownership.
- R12: Reads of identifiers 8, 9 and 10 are always aborted.
- R13: With `acc_valid` high exactly one of `acc_perform` and `acc_abort` is 1. With `acc_valid` low both are 0.
- R14: Ownership changes only through the events of R4, R5, R10 and R11. An aborted access never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A decoded access is present this cycle |
| acc_loc | input | 3 | Locality number of the access |
| acc_rid | input | 4 | Register identifier (encoding in R2 to R12) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 2 | Access-control write bits: bit 0 request, bit 1 relinquish |
| fifo_avail | input | 1 | Response data available in the FIFO |
| acc_perform | output | 1 | Access is carried out and acknowledged |
| acc_abort | output | 1 | Access is dropped without acknowledge |
| owner_valid | output | 1 | Some locality owns the module |
| owner_loc | output | 3 | Owning locality (0 while none) |

## Verification
The assertions assume the decoder holds `acc_loc`, `acc_rid`, `acc_write` and `acc_wdata` at known values whenever `acc_valid` is high, and that one access is presented per cycle. The properties on ownership also assume the register file acts only on `acc_perform`. The random stimulus draws every input field from its full width, including out-of-range localities and unused identifiers, so it stays inside those assumptions while still reaching illegal codes. A directed sweep forces each of the six ownership states before every locality, identifier and direction combination.

// File: rtl/lac_pkg.sv
package lac_pkg;

  // Locality and identifier widths shared by every unit
  localparam int LOC_W    = 3;
  localparam int RID_W    = 4;
  localparam int NUM_LOC  = 5;
  localparam int HASH_LOC = 4;

  // Register identifiers decoded by the bus front end
  localparam logic [RID_W-1:0] RID_ACCESS   = 4'd0;
  localparam logic [RID_W-1:0] RID_INT_EN   = 4'd1;
  localparam logic [RID_W-1:0] RID_INT_VEC  = 4'd2;
  localparam logic [RID_W-1:0] RID_INT_STS  = 4'd3;
  localparam logic [RID_W-1:0] RID_INT_CAP  = 4'd4;
  localparam logic [RID_W-1:0] RID_STATUS   = 4'd5;
  localparam logic [RID_W-1:0] RID_FIFO     = 4'd6;
  localparam logic [RID_W-1:0] RID_IFCFG    = 4'd7;
  localparam logic [RID_W-1:0] RID_HSTART   = 4'd8;
  localparam logic [RID_W-1:0] RID_HDATA    = 4'd9;
  localparam logic [RID_W-1:0] RID_HEND     = 4'd10;

  // Bit positions in an access-control write
  localparam int REQ_BIT = 0;
  localparam int REL_BIT = 1;

  // Relationship of the addressed locality to the current owner
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_SELF  = 2'd1,
    OWN_OTHER = 2'd2
  } own_e;

  // Matrix lookup: is the access allowed at all
  function automatic logic rule_allows(input logic [RID_W-1:0] rid,
                                       input logic wr,
                                       input own_e own,
                                       input logic avail,
                                       input logic hash_loc);
    logic self_o;
    logic none_o;
    self_o = (own == OWN_SELF);
    none_o = (own == OWN_NONE);
    case (rid)
      RID_ACCESS:                         return 1'b1;
      RID_INT_EN, RID_INT_VEC,
      RID_INT_STS, RID_IFCFG:             return !wr || self_o;
      RID_INT_CAP:                        return !wr;
      RID_STATUS:                         return self_o;
      RID_FIFO:                           return self_o && (wr || avail);
      RID_HSTART:                         return wr && hash_loc && none_o;
      RID_HDATA, RID_HEND:                return wr && hash_loc && self_o;
      default:                            return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lac_classify.sv
module lac_classify
  import lac_pkg::*;
(
  input  logic [LOC_W-1:0] loc,
  input  logic             own_valid,
  input  logic [LOC_W-1:0] own_loc,
  output logic             loc_ok,
  output logic             loc_is_hash,
  output own_e             rel_own
);

  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);
  localparam logic [LOC_W-1:0] HASH_ID  = LOC_W'(HASH_LOC);

  assign loc_ok      = (loc <= LAST_LOC);
  assign loc_is_hash = (loc == HASH_ID);

  always_comb begin
    if (!own_valid)          rel_own = OWN_NONE;
    else if (own_loc == loc) rel_own = OWN_SELF;
    else                     rel_own = OWN_OTHER;
  end

endmodule

// File: rtl/lac_rules.sv
module lac_rules
  import lac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [RID_W-1:0] rid,
  input  logic             wr,
  input  logic [1:0]       wdata,
  input  logic             avail,
  input  logic             loc_ok,
  input  logic             loc_is_hash,
  input  own_e             rel_own,
  output logic             ok,
  output logic             grant_evt,
  output logic             rel_evt
);

  logic allow_raw;
  logic is_ctl_wr;

  assign allow_raw = rule_allows(rid, wr, rel_own, avail, loc_is_hash);
  assign ok        = valid && loc_ok && allow_raw;
  assign is_ctl_wr = ok && wr && (rid == RID_ACCESS);

  // Relinquish by the owner wins over a simultaneous request
  assign rel_evt   = (is_ctl_wr && wdata[REL_BIT] && (rel_own == OWN_SELF))
                   || (ok && wr && (rid == RID_HEND));
  assign grant_evt = (is_ctl_wr && wdata[REQ_BIT] && (rel_own == OWN_NONE))
                   || (ok && wr && (rid == RID_HSTART));

  // R8: FIFO read without data never goes through
  a_r8_fifo_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rid == RID_FIFO && !wr && !avail) |-> !ok);

  // R9: capability register is read-only
  a_r9_cap_write: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rid == RID_INT_CAP && wr) |-> !ok);

  // R12: hash registers cannot be read
  a_r12_hash_read: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !wr && (rid == RID_HSTART || rid == RID_HDATA || rid == RID_HEND)) |-> !ok);

  // R10: a hash start only ever comes from an idle module
  a_r10_hstart_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && wr && rid == RID_HSTART) |-> (rel_own == OWN_NONE && loc_is_hash));

  // R14: grant and release never coincide
  a_r14_evt_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_evt && rel_evt));

endmodule

// File: rtl/lac_owner.sv
module lac_owner
  import lac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_evt,
  input  logic             rel_evt,
  input  logic [LOC_W-1:0] grant_loc,
  output logic             own_valid,
  output logic [LOC_W-1:0] own_loc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_valid <= 1'b0;
      own_loc   <= '0;
    end else if (rel_evt) begin
      own_valid <= 1'b0;
      own_loc   <= '0;
    end else if (grant_evt) begin
      own_valid <= 1'b1;
      own_loc   <= grant_loc;
    end
  end

  // R4 / R10: a grant installs the requesting locality
  a_r4_grant_installs: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_evt && !rel_evt) |=> (own_valid && own_loc == $past(grant_loc)));

  // R5 / R11: a release leaves no owner
  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> !own_valid);

  // R14: without an event the ownership holds
  a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_evt && !rel_evt) |=> ($stable(own_valid) && $stable(own_loc)));

  // R1: idle ownership reports locality zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !own_valid |-> (own_loc == '0));

endmodule

// File: rtl/lac_gate.sv
module lac_gate
  import lac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [2:0]       acc_loc,
  input  logic [3:0]       acc_rid,
  input  logic             acc_write,
  input  logic [1:0]       acc_wdata,
  input  logic             fifo_avail,
  output logic             acc_perform,
  output logic             acc_abort,
  output logic             owner_valid,
  output logic [2:0]       owner_loc
);

  logic loc_ok;
  logic loc_is_hash;
  own_e rel_own;
  logic ok;
  logic grant_evt;
  logic rel_evt;

  lac_classify u_classify (
    .loc         (acc_loc),
    .own_valid   (owner_valid),
    .own_loc     (owner_loc),
    .loc_ok      (loc_ok),
    .loc_is_hash (loc_is_hash),
    .rel_own     (rel_own)
  );

  lac_rules u_rules (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (acc_valid),
    .rid         (acc_rid),
    .wr          (acc_write),
    .wdata       (acc_wdata),
    .avail       (fifo_avail),
    .loc_ok      (loc_ok),
    .loc_is_hash (loc_is_hash),
    .rel_own     (rel_own),
    .ok          (ok),
    .grant_evt   (grant_evt),
    .rel_evt     (rel_evt)
  );

  lac_owner u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_evt (grant_evt),
    .rel_evt   (rel_evt),
    .grant_loc (acc_loc),
    .own_valid (owner_valid),
    .own_loc   (owner_loc)
  );

  assign acc_perform = ok;
  assign acc_abort   = acc_valid && !ok;

  // R13: one verdict per access, none while idle
  a_r13_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_perform ^ acc_abort));
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_perform && !acc_abort));

  // R2: out-of-range locality is dropped
  a_r2_bad_loc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_loc > 3'd4) |-> acc_abort);

  // R3: access-control register always reachable for a valid locality
  a_r3_access_open: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_loc <= 3'd4 && acc_rid == RID_ACCESS) |-> acc_perform);

  // R11: a performed hash end leaves the module unowned
  a_r11_hend_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_perform && acc_write && acc_rid == RID_HEND) |=> !owner_valid);

endmodule

// File: tb/lac_gate_tb.sv
module lac_gate_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid;
  logic [2:0] acc_loc;
  logic [3:0] acc_rid;
  logic       acc_write;
  logic [1:0] acc_wdata;
  logic       fifo_avail;
  logic       acc_perform;
  logic       acc_abort;
  logic       owner_valid;
  logic [2:0] owner_loc;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // bench model of ownership
  bit       m_valid = 0;
  bit [2:0] m_loc   = 0;

  always #2.5 clk = ~clk;

  lac_gate dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_loc(acc_loc),
    .acc_rid(acc_rid), .acc_write(acc_write), .acc_wdata(acc_wdata),
    .fifo_avail(fifo_avail), .acc_perform(acc_perform), .acc_abort(acc_abort),
    .owner_valid(owner_valid), .owner_loc(owner_loc)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int loc, input int rid, input bit wr);
    if (loc > 4 || rid > 10) return "R2";
    if (rid == 0) return "R3";
    if (rid == 4 && wr) return "R9";
    if (rid == 6 && !wr) return "R8";
    if (rid >= 8 && !wr) return "R12";
    if (rid == 8) return "R10";
    if (rid >= 9) return "R11";
    if (wr) return "R6";
    return "R7";
  endfunction

  // expected verdict from the requirement table
  function automatic bit exp_ok(input int loc, input int rid, input bit wr, input bit av);
    bit own_s, none_s;
    if (loc > 4) return 0;
    own_s  = m_valid && (m_loc == loc);
    none_s = !m_valid;
    case (rid)
      0:          return 1;
      1, 2, 3, 7: return wr ? own_s : 1'b1;
      4:          return !wr;
      5:          return own_s;
      6:          return wr ? own_s : (own_s && av);
      8:          return wr && loc == 4 && none_s;
      9, 10:      return wr && loc == 4 && own_s;
      default:    return 0;
    endcase
  endfunction

  task automatic access(input int loc, input int rid, input bit wr,
                        input bit [1:0] wd, input bit av);
    bit e;
    bit own_s;
    @(negedge clk);
    acc_valid = 1; acc_loc = 3'(loc); acc_rid = 4'(rid);
    acc_write = wr; acc_wdata = wd; fifo_avail = av;
    #1;
    e = exp_ok(loc, rid, wr, av);
    check(tag_of(loc, rid, wr), int'(acc_perform), int'(e));
    check("R13 verdict", int'(acc_perform ^ acc_abort), 1);
    own_s = m_valid && (m_loc == loc);
    if (e) begin
      if (rid == 0 && wr) begin
        if (wd[1] && own_s) m_valid = 0;
        else if (wd[0] && !m_valid) begin m_valid = 1; m_loc = 3'(loc); end
      end else if (rid == 8 && wr) begin m_valid = 1; m_loc = 3'd4; end
      else if (rid == 10 && wr) m_valid = 0;
      if (!m_valid) m_loc = 0;
    end
    @(posedge clk); #1;
    check("R14 owner_valid (R4 R5)", int'(owner_valid), int'(m_valid));
    check("R14 owner_loc", int'(owner_loc), int'(m_loc));
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0;
    #1;
    check("R13 idle", int'({acc_perform, acc_abort}), 0);
  endtask

  task automatic set_owner(input int o);
    if (m_valid) access(m_loc, 0, 1, 2'b10, 0);
    if (o >= 0) access(o, 0, 1, 2'b01, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; acc_valid = 0; acc_loc = 0; acc_rid = 0;
    acc_write = 0; acc_wdata = 0; fifo_avail = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 reset owner_valid", int'(owner_valid), 0);
    check("R1 reset owner_loc", int'(owner_loc), 0);
    idle();

    // R10 R11 directed hash sequence
    access(4, 8, 1, 0, 0);
    check("R10 hash start owner", int'(owner_loc), 4);
    access(4, 9, 1, 0, 0);
    access(4, 10, 1, 0, 0);
    check("R11 hash end frees", int'(owner_valid), 0);
    set_owner(2);
    access(4, 8, 1, 0, 0);
    check("R10 blocked start keeps owner", int'(owner_loc), 2);
    // R5 non-owner release ignored, R4 request while owned ignored
    access(1, 0, 1, 2'b11, 0);
    check("R5 foreign release", int'(owner_loc), 2);
    // R5 priority of release over request
    access(2, 0, 1, 2'b11, 0);
    check("R5 release priority", int'(owner_valid), 0);
    // R8 owner FIFO read with and without data
    set_owner(3);
    access(3, 6, 0, 0, 0);
    access(3, 6, 0, 0, 1);

    // full sweep of ownership state x locality x identifier x direction
    for (int st = -1; st <= 4; st++) begin
      for (int l = 0; l < 8; l++) begin
        for (int r = 0; r < 16; r++) begin
          for (int w = 0; w < 2; w++) begin
            set_owner(st);
            access(l, r, w[0], 2'($urandom % 4), 1'($urandom % 2));
          end
        end
      end
    end

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int l, r;
      l = ($urandom % 4 == 0) ? 4 : int'($urandom % 8);
      r = ($urandom % 3 == 0) ? int'($urandom % 2) * 8 + 2 : int'($urandom % 16);
      access(l, r, 1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2));
      if (i % 50 == 0) idle();
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule